// File: doc/BRIEF.md
# Banked GPIO Register File with Keyed Pin Locks

This block is the register file of a general-purpose I/O controller whose pins come in banks of 32. The number of banks is a parameter from 1 to 8. A simple memory-mapped read/write bus reaches it. For each pin it stores a direction bit. For each bank it stores an output latch that is changed through separate set and clear ports. It also presents the pad inputs of each bank after a two-flop synchronizer. It drives the pad output values and the active-high output enables.

Each bank has a lock word in which a 1 protects a pin. A protected pin ignores any change to its direction or its output value. The lock word itself can only be rewritten by the bus write that comes directly after a key write. A key write is the value 0x00A5A501 written to byte offset 0x520. This makes it hard for a stray write to free or take over a pin. Reset leaves every pin an input, drives every output latch low and locks every bank.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin is an input (pad_oe_o all 0), every output latch is 0, every lock word reads 0xFFFFFFFF and rvalid_o is 0.
- R2: A read sampled at a clock edge returns its data on rdata_o with rvalid_o high in the following cycle. rvalid_o is low in every cycle after a clock edge that sampled no read. Addresses that are not mapped, including the registers of banks at or above NBANKS, read as 0.
- R3: A write to the output-set register of bank b (offset 0x040 + 4b) sets to 1 each unlocked output latch bit whose written bit is 1. Bits written as 0 keep their value. Latch bit i of bank b drives pad_out_o[32b+i].
- R4: A write to the output-clear register of bank b (offset 0x060 + 4b) clears to 0 each unlocked latch bit whose written bit is 1. Bits written as 0 keep their value.
- R5: The control word of pin p is at offset 0x100 + 4p. Only its bit 0 is stored: 1 makes the pin an input, with pad_oe_o[p] = 0; 0 makes it an output, with pad_oe_o[p] = 1. A read returns the stored bit in bit 0, and the other bits read as 0.
- R6: Writing exactly 0x00A5A501 to offset 0x520 arms the lock port for the next bus write only. If that write targets the lock word of bank b (offset 0x500 + 4b), the written value replaces the lock word. A second lock write without a new key has no effect.
- R7: A lock write that does not directly follow a key write is ignored. So is a lock write that follows a key write with any other value, or one that has a different write between it and the key. Reads do not disarm the port.
- R8: While a pin's lock bit is 1, writes to its control word and to the set and clear registers leave its direction and its output latch unchanged.
- R9: The input-state register of bank b (offset 0x020 + 4b) returns the pad inputs through a two-flop synchronizer. A pad change made before clock edge k is returned by a read sampled at edge k+2. Reads sampled at edges k and k+1 still return the old value.
- R10: The output-state register of bank b (offset 0x000 + 4b) returns the output latch. Writes to the output-state and input-state registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| pad_in_i | input | 32*NBANKS | Asynchronous pad input levels |
| pad_out_o | output | 32*NBANKS | Pad output values |
| pad_oe_o | output | 32*NBANKS | Pad output enables, 1 = driving |

## Verification
The bench first targets the key sequence. It tries a lock write with no key, a key with an off-by-one value, a key followed by an unrelated write, and a second lock write after a valid key. A design that armed on the address alone, or that stayed armed for longer than one write, would open the bank at one of these steps. Locked and unlocked pins are mixed inside one set, clear and control write. This exposes a design that applied the mask to only one of the three ports. The synchronizer is checked by back-to-back reads around a pad change, so a design with one flop too many or too few returns the new value in the wrong read. The bench also writes to bank 2, which does not exist, and to the read-only registers. A design that did not decode these correctly would alias them onto real state.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int PINS_PER_BANK = 32;
  localparam int MAX_BANKS     = 8;
  localparam int CTRL_BASE     = 'h100;
  localparam int LOCK_BASE     = 'h500;
  localparam int KEY_ADDR      = 'h520;
  localparam logic [31:0] KEY_WORD = 32'h00A5_A501;

  // bank register group, address bits [7:5] below CTRL_BASE
  typedef enum logic [2:0] {
    GRP_OUT = 3'd0,
    GRP_IN  = 3'd1,
    GRP_SET = 3'd2,
    GRP_CLR = 3'd3
  } grp_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_key_arm.sv
module gpio_key_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,      // any bus write this cycle
  input  logic key_ok_i,  // that write is the correct key
  output logic armed_o
);
  logic armed_q;

  // every write re-evaluates: only a key write leaves the port armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= key_ok_i;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic         lock_we_i,
  input  logic [W-1:0] ctrl_we_i,
  input  logic         ctrl_dir_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] lock_o,
  output logic [W-1:0] in_o
);
  logic [W-1:0] out_q, dir_q, lock_q;
  logic [W-1:0] free, hit, dir_upd;

  assign free    = ~lock_q;
  assign hit     = wdata_i & free;
  assign dir_upd = ctrl_we_i & free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '1;
      lock_q <= '1;
    end else begin
      if (set_we_i)      out_q <= out_q | hit;
      else if (clr_we_i) out_q <= out_q & ~hit;
      dir_q <= (dir_q & ~dir_upd) | ({W{ctrl_dir_i}} & dir_upd);
      if (lock_we_i) lock_q <= wdata_i;
    end
  end

  gpio_sync2 #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_o)
  );

  assign out_o  = out_q;
  assign dir_o  = dir_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_regs_pkg::*;
#(
  parameter int NBANKS = 2,
  parameter int ADDR_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  output logic                         rvalid_o,
  output logic [31:0]                  rdata_o,
  input  logic [PINS_PER_BANK*NBANKS-1:0] pad_in_i,
  output logic [PINS_PER_BANK*NBANKS-1:0] pad_out_o,
  output logic [PINS_PER_BANK*NBANKS-1:0] pad_oe_o
);
  localparam int NPINS = PINS_PER_BANK * NBANKS;
  localparam int PIN_W = $clog2(NPINS);

  logic             is_wr, is_rd;
  logic             lo_hit, ctrl_hit, lock_hit, key_hit;
  grp_e             grp;
  logic [2:0]       bsel;
  logic [PIN_W-1:0] pin_idx;
  logic [NPINS-1:0] ctrl_we, dir_all, lock_all;
  logic             armed;
  logic [31:0]      out_b  [MAX_BANKS];
  logic [31:0]      in_b   [MAX_BANKS];
  logic [31:0]      lock_b [MAX_BANKS];
  logic [31:0]      rd_val, rdata_q;
  logic             rvalid_q;

  assign is_wr    = req_i & we_i;
  assign is_rd    = req_i & ~we_i;
  assign grp      = grp_e'(addr_i[7:5]);
  assign bsel     = addr_i[4:2];
  assign lo_hit   = int'(addr_i) < CTRL_BASE;
  assign ctrl_hit = int'(addr_i) >= CTRL_BASE && int'(addr_i) < CTRL_BASE + 4 * NPINS;
  assign lock_hit = (int'(addr_i) >> 5) == (LOCK_BASE >> 5);
  assign key_hit  = int'(addr_i) == KEY_ADDR;
  assign pin_idx  = PIN_W'((int'(addr_i) - CTRL_BASE) >> 2);
  assign ctrl_we  = (is_wr && ctrl_hit) ? (NPINS'(1) << pin_idx) : '0;

  gpio_key_arm u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (is_wr),
    .key_ok_i(key_hit && wdata_i == KEY_WORD),
    .armed_o (armed)
  );

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    if (b < NBANKS) begin : g_on
      localparam int LO = b * PINS_PER_BANK;
      logic [31:0] dir_q;
      gpio_bank #(.W(PINS_PER_BANK)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_we_i  (is_wr && lo_hit && grp == GRP_SET && int'(bsel) == b),
        .clr_we_i  (is_wr && lo_hit && grp == GRP_CLR && int'(bsel) == b),
        .lock_we_i (is_wr && lock_hit && armed && int'(bsel) == b),
        .ctrl_we_i (ctrl_we[LO +: PINS_PER_BANK]),
        .ctrl_dir_i(wdata_i[0]),
        .wdata_i   (wdata_i),
        .pad_in_i  (pad_in_i[LO +: PINS_PER_BANK]),
        .out_o     (out_b[b]),
        .dir_o     (dir_q),
        .lock_o    (lock_b[b]),
        .in_o      (in_b[b])
      );
      assign dir_all[LO +: PINS_PER_BANK]   = dir_q;
      assign lock_all[LO +: PINS_PER_BANK]  = lock_b[b];
      assign pad_out_o[LO +: PINS_PER_BANK] = out_b[b];
    end else begin : g_off
      assign out_b[b]  = '0;
      assign in_b[b]   = '0;
      assign lock_b[b] = '0;
    end
  end

  assign pad_oe_o = ~dir_all;

  always_comb begin
    rd_val = '0;
    if (lo_hit) begin
      case (grp)
        GRP_OUT: rd_val = out_b[bsel];
        GRP_IN:  rd_val = in_b[bsel];
        default: rd_val = '0;
      endcase
    end else if (ctrl_hit) begin
      rd_val = {31'b0, dir_all[pin_idx]};
    end else if (lock_hit) begin
      rd_val = lock_b[bsel];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= is_rd;
      if (is_rd) rdata_q <= rd_val;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int NPINS  = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rvalid_o,
  input logic [NPINS-1:0]  pad_out_o,
  input logic [NPINS-1:0]  pad_oe_o,
  input logic [NPINS-1:0]  lock_all,
  input logic              armed
);
  logic lock_wr, key_wr, set0_wr;
  assign lock_wr = req_i && we_i && ((int'(addr_i) >> 5) == ('h500 >> 5));
  assign key_wr  = req_i && we_i && int'(addr_i) == 'h520 && wdata_i == 32'h00A5_A501;
  assign set0_wr = req_i && we_i && int'(addr_i) == 'h040;

  assert_locked_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ $past(pad_oe_o)) & $past(lock_all)) == '0);

  assert_locked_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ $past(pad_out_o)) & $past(lock_all)) == '0);

  assert_lock_needs_key_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_all != $past(lock_all)) |-> $past(armed && lock_wr));

  assert_key_arms_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr |=> armed);

  assert_read_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  assert_set_drives_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set0_wr |=> (pad_out_o[31:0] & $past(wdata_i & ~lock_all[31:0])) == $past(wdata_i & ~lock_all[31:0]));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rvalid_o (rvalid_o),
  .pad_out_o(pad_out_o),
  .pad_oe_o (pad_oe_o),
  .lock_all (lock_all),
  .armed    (armed)
);

// File: tb/gpio_bank_regs_bench.sv
`timescale 1ns/1ps
module gpio_bank_regs_bench;
  localparam int NB = 2;
  localparam int NP = 32 * NB;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic          rvalid_o;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pad_in_i = '0;
  logic [NP-1:0] pad_out_o, pad_oe_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t it;

  always #2.5 clk_i = ~clk_i;

  gpio_bank_regs #(.NBANKS(NB), .ADDR_W(12)) u_gpio_bank_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .pad_in_i(pad_in_i),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.exp = e; x.tag = tag;
    exp_q.push_back(x);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  // monitor: compares read data in the cycle after each read
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: actual unexpected rvalid data %h expected no read", rdata_o);
      end else begin
        it = exp_q.pop_front();
        if (rdata_o !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdata_o, it.exp);
        end
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(64'(pad_oe_o), '0, "R1 oe at reset");
    chk(64'(pad_out_o), '0, "R1 out at reset");
    chk(64'(rvalid_o), 0, "R1 rvalid at reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    bus_rd(12'h500, 32'hFFFF_FFFF, "R1 lock0 at reset");
    bus_rd(12'h504, 32'hFFFF_FFFF, "R1 lock1 at reset");
    bus_rd(12'h100, 32'h1, "R1 R5 ctrl0 input at reset");

    // locked bank ignores set and control
    bus_wr(12'h040, 32'hFFFF_FFFF);
    chk(64'(pad_out_o), '0, "R8 set on locked bank");
    chk(64'(rvalid_o), 0, "R2 no rvalid after write");
    bus_wr(12'h10C, 32'h0);
    chk(64'(pad_oe_o), '0, "R8 ctrl on locked pin");
    bus_rd(12'h10C, 32'h1, "R8 ctrl3 readback");

    // bad key sequences
    bus_wr(12'h500, 32'h0);
    bus_rd(12'h500, 32'hFFFF_FFFF, "R7 lock without key");
    bus_wr(12'h520, 32'h00A5_A500);
    bus_wr(12'h500, 32'h0);
    bus_rd(12'h500, 32'hFFFF_FFFF, "R7 wrong key value");
    bus_wr(12'h520, 32'h00A5_A501);
    bus_wr(12'h044, 32'h0);
    bus_wr(12'h500, 32'h0);
    bus_rd(12'h500, 32'hFFFF_FFFF, "R7 write between key and lock");

    // good key, read in between does not disarm
    bus_wr(12'h520, 32'h00A5_A501);
    bus_rd(12'h504, 32'hFFFF_FFFF, "R7 read while armed");
    bus_wr(12'h500, 32'hFFFF_0000);
    bus_rd(12'h500, 32'hFFFF_0000, "R6 keyed lock write");
    bus_wr(12'h500, 32'h0);
    bus_rd(12'h500, 32'hFFFF_0000, "R6 key used once");

    // direction
    for (int p = 0; p < 8; p++) bus_wr(12'(32'h100 + 4 * p), 32'h0);
    bus_wr(12'h104, 32'hFFFF_FFFE);
    bus_wr(12'h150, 32'h0);
    chk(64'(pad_oe_o), 64'h0000_0000_0000_00FF, "R5 R8 outputs enabled");
    bus_wr(12'h11C, 32'h1);
    chk(64'(pad_oe_o), 64'h0000_0000_0000_007F, "R5 pin back to input");
    bus_rd(12'h104, 32'h0, "R5 ctrl1 only bit0 kept");

    // set / clear with partial lock
    bus_wr(12'h040, 32'h0010_00A5);
    chk(64'(pad_out_o), 64'h0000_00A5, "R3 R8 set partial lock");
    bus_wr(12'h040, 32'h0000_0100);
    chk(64'(pad_out_o), 64'h0000_01A5, "R3 set keeps zeros");
    bus_wr(12'h060, 32'h0000_0021);
    chk(64'(pad_out_o), 64'h0000_0184, "R4 clear");
    bus_wr(12'h060, 32'h0);
    chk(64'(pad_out_o), 64'h0000_0184, "R4 clear of zeros");
    bus_wr(12'h000, 32'hFFFF_FFFF);
    bus_rd(12'h000, 32'h0000_0184, "R10 out state read-only");

    // bank 1
    bus_wr(12'h520, 32'h00A5_A501);
    bus_wr(12'h504, 32'h0);
    bus_wr(12'h044, 32'h8000_0001);
    chk(64'(pad_out_o), 64'h8000_0001_0000_0184, "R3 bank1 set");
    bus_rd(12'h004, 32'h8000_0001, "R10 out state bank1");
    bus_wr(12'h1FC, 32'h0);
    chk(64'(pad_oe_o), 64'h8000_0000_0000_007F, "R5 last pin output");

    // relock bank0
    bus_wr(12'h520, 32'h00A5_A501);
    bus_wr(12'h500, 32'hFFFF_FFFF);
    bus_wr(12'h060, 32'hFFFF_FFFF);
    chk(64'(pad_out_o), 64'h8000_0001_0000_0184, "R8 clear after relock");

    // input synchronizer
    pad_in_i = 64'hCAFE_0000_1234_5678;
    bus_rd(12'h020, 32'h0, "R9 sync edge k");
    bus_rd(12'h020, 32'h0, "R9 sync edge k+1");
    bus_rd(12'h020, 32'h1234_5678, "R9 sync edge k+2");
    bus_rd(12'h024, 32'hCAFE_0000, "R9 bank1 input");
    bus_wr(12'h020, 32'h0);
    bus_rd(12'h020, 32'h1234_5678, "R10 in state read-only");

    // unmapped and absent bank
    bus_wr(12'h048, 32'hFFFF_FFFF);
    bus_rd(12'h008, 32'h0, "R2 absent bank out");
    bus_rd(12'h508, 32'h0, "R2 absent bank lock");
    bus_rd(12'h080, 32'h0, "R2 unmapped group");
    bus_rd(12'h200, 32'h0, "R2 ctrl beyond last pin");
    chk(64'(pad_out_o), 64'h8000_0001_0000_0184, "R2 absent bank write ignored");

    repeat (2) @(negedge clk_i);
    chk(64'(exp_q.size()), 0, "R2 all reads answered");
    done = 1'b1;
    finish_run();
  end
endmodule